// File: doc/BRIEF.md
# Selectable Audio De-emphasis Filter

This block applies a first-order shelving de-emphasis curve to a bank of signed 24-bit PCM channels. The curve is built from pole and zero time constants of 50 µs and 15 µs. A 2-bit curve code picks one of three built-in fixed-point coefficient sets (for 32, 44.1 or 48 kHz base rates) or switches the filter off. One sample per channel enters on each frame strobe, and one result per channel leaves one clock later, together with a valid flag.

The channels are grouped by converter. Each converter has an enable bit that decides whether its channels follow the shared curve code or pass through untouched. The filter only runs in normal-speed operation. Whenever the speed code reports double, quad or the reserved setting, every channel is bypassed. Bypass keeps the same one-strobe latency as filtering, so a change of configuration never shifts the output timing.

Each channel is a one-pole, one-zero IIR with Q1.15 coefficients, rounding, and clamping to the 24-bit range. Its history is cleared whenever the channel leaves filtering or its curve changes, so stale state cannot cause a transient.

Top module: `deemph_bank`

## Requirements
- R1: While reset is asserted, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is 1 in exactly the one clock that follows each clock in which `frame_stb` is 1, and 0 otherwise. `out_data` changes only on those clocks.
- R3: Curve code 01 means off: every channel outputs its input sample unchanged, one strobe later.
- R4: Speed code 00 means normal speed. Any other speed code (01 double, 10 quad, 11 reserved) bypasses every channel, whatever the curve code says.
- R5: Channel c (bits [24c+23:24c] of the sample buses) belongs to converter c / CH_PER_DAC. It passes its input unchanged whenever that converter's `dac_en` bit is 0.
- R6: A filtering channel outputs y = (b0·x + b1·x1 + f·y1 + 2^14) >>> 15, clamped to [-2^23, 2^23-1]. Here x1 and y1 are the previous input and output of that channel. The coefficients (b0, b1, f) are (14070, -1956, 20654) for code 00 (44.1 kHz), (13785, -2486, 21469) for code 10 (48 kHz), and (15292, 312, 17164) for code 11 (32 kHz).
- R7: A filtering channel uses zero in place of x1 and y1 when it was not filtering at its previous strobe, or when the curve code differs from the code at its previous strobe. A bypassed channel keeps zero history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_stb | input | 1 | One-cycle frame strobe; samples are taken on this clock |
| curve_sel | input | 2 | Curve code: 00 44.1 kHz, 01 off, 10 48 kHz, 11 32 kHz |
| speed_sel | input | 2 | Speed code: 00 normal, 01 double, 10 quad, 11 reserved |
| dac_en | input | NUM_DAC | Per-converter filter enable |
| in_data | input | NUM_DAC*CH_PER_DAC*DATA_W | Packed signed input samples, channel 0 in the low bits |
| out_data | output | NUM_DAC*CH_PER_DAC*DATA_W | Packed signed output samples, held between strobes |
| out_valid | output | 1 | High for one clock after each strobe |

## Verification
Every result is due on the clock edge that samples `frame_stb`: one register stage for the data and one for the valid flag. The bench drives a strobe at a falling edge and checks `out_valid` and every channel at the next falling edge. It then holds the strobe low for one to three cycles and checks there that `out_valid` stays low and `out_data` holds, while `in_data` is scrambled. The expected values come from a per-channel model of R3 to R7, which is advanced only at strobes. A history-reset frame is therefore graded in the same cycle as any other frame.

// File: rtl/deemph_pkg.sv
package deemph_pkg;

  localparam int COEF_W = 16;
  localparam int FRAC_W = 15;

  typedef enum logic [1:0] {
    CURVE_441 = 2'b00,
    CURVE_OFF = 2'b01,
    CURVE_48  = 2'b10,
    CURVE_32  = 2'b11
  } curve_e;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } speed_e;

  // feed-forward taps b0, b1 and feedback tap fb (fb = -a1)
  typedef struct packed {
    logic [COEF_W-1:0] b0;
    logic [COEF_W-1:0] b1;
    logic [COEF_W-1:0] fb;
  } coef_t;

endpackage

// File: rtl/deemph_coef_sel.sv
module deemph_coef_sel
  import deemph_pkg::*;
(
  input  logic [1:0] curve_sel,
  output coef_t      coef
);

  // Bilinear-mapped 50/15 us shelf; b0 + b1 == 2^15 - fb so DC gain is unity
  always_comb begin
    coef = '0;
    case (curve_sel)
      CURVE_441: begin
        coef.b0 = 16'sd14070;
        coef.b1 = -16'sd1956;
        coef.fb = 16'sd20654;
      end
      CURVE_48: begin
        coef.b0 = 16'sd13785;
        coef.b1 = -16'sd2486;
        coef.fb = 16'sd21469;
      end
      CURVE_32: begin
        coef.b0 = 16'sd15292;
        coef.b1 = 16'sd312;
        coef.fb = 16'sd17164;
      end
      default: coef = '0;
    endcase
  end

endmodule

// File: rtl/deemph_lane_ctl.sv
module deemph_lane_ctl
  import deemph_pkg::*;
#(
  parameter int NUM_DAC = 3
) (
  input  logic [1:0]         curve_sel,
  input  logic [1:0]         speed_sel,
  input  logic [NUM_DAC-1:0] dac_en,
  output logic [NUM_DAC-1:0] dac_active
);

  logic curve_on;

  assign curve_on = (speed_sel == SPD_NORMAL) && (curve_sel != CURVE_OFF);

  for (genvar d = 0; d < NUM_DAC; d++) begin : g_dac
    assign dac_active[d] = curve_on & dac_en[d];
  end

endmodule

// File: rtl/deemph_ch.sv
module deemph_ch
  import deemph_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              active,
  input  logic [1:0]        curve_sel,
  input  coef_t             coef,
  input  logic [DATA_W-1:0] x_in,
  output logic [DATA_W-1:0] y_out
);

  localparam int ACC_W = DATA_W + COEF_W + 2;
  localparam int EXT_D = ACC_W - DATA_W;
  localparam int EXT_C = ACC_W - COEF_W;
  localparam logic signed [ACC_W-1:0] RND = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MAX = {1'b1, {(DATA_W-1){1'b0}}};

  // state
  logic [DATA_W-1:0] x1_q, y1_q, y_q;
  logic              act_q;
  logic [1:0]        curve_q;

  // next state
  logic [DATA_W-1:0] x1_nxt, y1_nxt, y_nxt;

  // datapath
  logic                    hist_ok;
  logic [DATA_W-1:0]       x1_use, y1_use;
  logic signed [ACC_W-1:0] x_e, x1_e, y1_e;
  logic signed [ACC_W-1:0] b0_e, b1_e, fb_e;
  logic signed [ACC_W-1:0] acc, shifted;
  logic                    fits;
  logic [DATA_W-1:0]       sat;

  always_comb begin
    hist_ok = act_q && (curve_q == curve_sel);
    x1_use  = hist_ok ? x1_q : '0;
    y1_use  = hist_ok ? y1_q : '0;

    x_e  = {{EXT_D{x_in[DATA_W-1]}},   x_in};
    x1_e = {{EXT_D{x1_use[DATA_W-1]}}, x1_use};
    y1_e = {{EXT_D{y1_use[DATA_W-1]}}, y1_use};
    b0_e = {{EXT_C{coef.b0[COEF_W-1]}}, coef.b0};
    b1_e = {{EXT_C{coef.b1[COEF_W-1]}}, coef.b1};
    fb_e = {{EXT_C{coef.fb[COEF_W-1]}}, coef.fb};

    acc     = (x_e * b0_e) + (x1_e * b1_e) + (y1_e * fb_e) + RND;
    shifted = acc >>> FRAC_W;

    fits = (&shifted[ACC_W-1:DATA_W-1]) | ~(|shifted[ACC_W-1:DATA_W-1]);
    if (fits)
      sat = shifted[DATA_W-1:0];
    else if (shifted[ACC_W-1])
      sat = NEG_MAX;
    else
      sat = POS_MAX;

    y_nxt  = active ? sat  : x_in;
    x1_nxt = active ? x_in : '0;
    y1_nxt = active ? sat  : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1_q    <= '0;
      y1_q    <= '0;
      y_q     <= '0;
      act_q   <= 1'b0;
      curve_q <= 2'b00;
    end else if (stb) begin
      x1_q    <= x1_nxt;
      y1_q    <= y1_nxt;
      y_q     <= y_nxt;
      act_q   <= active;
      curve_q <= curve_sel;
    end
  end

  assign y_out = y_q;

endmodule

// File: rtl/deemph_bank.sv
module deemph_bank
  import deemph_pkg::*;
#(
  parameter int NUM_DAC    = 3,
  parameter int CH_PER_DAC = 2,
  parameter int DATA_W     = 24
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 frame_stb,
  input  logic [1:0]                           curve_sel,
  input  logic [1:0]                           speed_sel,
  input  logic [NUM_DAC-1:0]                   dac_en,
  input  logic [NUM_DAC*CH_PER_DAC*DATA_W-1:0] in_data,
  output logic [NUM_DAC*CH_PER_DAC*DATA_W-1:0] out_data,
  output logic                                 out_valid
);

  localparam int NCH = NUM_DAC * CH_PER_DAC;

  coef_t              coef;
  logic [NUM_DAC-1:0] dac_active;
  logic               vld_nxt, vld_q;

  deemph_coef_sel u_coef (
    .curve_sel (curve_sel),
    .coef      (coef)
  );

  deemph_lane_ctl #(.NUM_DAC(NUM_DAC)) u_ctl (
    .curve_sel  (curve_sel),
    .speed_sel  (speed_sel),
    .dac_en     (dac_en),
    .dac_active (dac_active)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    deemph_ch #(.DATA_W(DATA_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb       (frame_stb),
      .active    (dac_active[c / CH_PER_DAC]),
      .curve_sel (curve_sel),
      .coef      (coef),
      .x_in      (in_data[c*DATA_W +: DATA_W]),
      .y_out     (out_data[c*DATA_W +: DATA_W])
    );
  end

  always_comb vld_nxt = frame_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_nxt;
  end

  assign out_valid = vld_q;

endmodule

// File: rtl/deemph_bank_chk.sv
module deemph_bank_chk #(
  parameter int NUM_DAC    = 3,
  parameter int CH_PER_DAC = 2,
  parameter int DATA_W     = 24
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 frame_stb,
  input logic [1:0]                           curve_sel,
  input logic [1:0]                           speed_sel,
  input logic [NUM_DAC-1:0]                   dac_en,
  input logic [NUM_DAC*CH_PER_DAC*DATA_W-1:0] in_data,
  input logic [NUM_DAC*CH_PER_DAC*DATA_W-1:0] out_data,
  input logic                                 out_valid
);

  localparam int NCH = NUM_DAC * CH_PER_DAC;

  always @(posedge clk) begin
    if (!rst_n)
      assert_reset_R1: assert (!out_valid && out_data == '0);
  end

  assert_valid_after_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> out_valid);

  assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> !out_valid);

  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(out_data));

  assert_off_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && curve_sel == 2'b01) |=> out_data == $past(in_data));

  assert_speed_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && speed_sel != 2'b00) |=> out_data == $past(in_data));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assert_dac_off_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !dac_en[c / CH_PER_DAC])
      |=> out_data[c*DATA_W +: DATA_W] == $past(in_data[c*DATA_W +: DATA_W]));
  end

endmodule

bind deemph_bank deemph_bank_chk #(
  .NUM_DAC    (NUM_DAC),
  .CH_PER_DAC (CH_PER_DAC),
  .DATA_W     (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_stb (frame_stb),
  .curve_sel (curve_sel),
  .speed_sel (speed_sel),
  .dac_en    (dac_en),
  .in_data   (in_data),
  .out_data  (out_data),
  .out_valid (out_valid)
);

// File: tb/sim_deemph_bank.sv
module sim_deemph_bank;

  localparam int ND  = 3;
  localparam int CPD = 2;
  localparam int DW  = 24;
  localparam int NCH = ND * CPD;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              frame_stb;
  logic [1:0]        curve_sel;
  logic [1:0]        speed_sel;
  logic [ND-1:0]     dac_en;
  logic [NCH*DW-1:0] in_data;
  logic [NCH*DW-1:0] out_data;
  logic              out_valid;

  int     n_tests = 0;
  int     n_fail  = 0;
  longint cur_x [NCH];
  longint m_x1  [NCH];
  longint m_y1  [NCH];
  bit     m_act [NCH];
  int     m_crv [NCH];

  always #2 clk = ~clk;

  deemph_bank #(.NUM_DAC(ND), .CH_PER_DAC(CPD), .DATA_W(DW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .curve_sel (curve_sel),
    .speed_sel (speed_sel),
    .dac_en    (dac_en),
    .in_data   (in_data),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint rnd_sample();
    logic [31:0] r = $urandom;
    longint v = longint'($signed(r[DW-1:0]));
    case ($urandom % 4)
      0:       return v >>> 8;
      1:       return v >>> 2;
      default: return v;
    endcase
  endfunction

  // Reference model of R3..R7 for one channel at one strobe
  function automatic longint model(input int c, input logic [1:0] crv, input logic [1:0] spd,
                                   input logic [ND-1:0] en, input longint x, output string tag);
    longint b0, b1, fb, x1, y1, acc, y;
    bit act;
    act = (spd == 2'b00) && (crv != 2'b01) && en[c / CPD];
    case (crv)
      2'b00:   begin b0 = 14070; b1 = -1956; fb = 20654; end
      2'b10:   begin b0 = 13785; b1 = -2486; fb = 21469; end
      2'b11:   begin b0 = 15292; b1 = 312;   fb = 17164; end
      default: begin b0 = 0;     b1 = 0;     fb = 0;     end
    endcase
    if (spd != 2'b00)       tag = "R4";
    else if (crv == 2'b01)  tag = "R3";
    else if (!en[c / CPD])  tag = "R5";
    else if (!(m_act[c] && m_crv[c] == int'(crv))) tag = "R7";
    else                    tag = "R6";
    if (!act) begin
      y = x;
      m_x1[c] = 0;
      m_y1[c] = 0;
    end else begin
      x1 = (m_act[c] && m_crv[c] == int'(crv)) ? m_x1[c] : 0;
      y1 = (m_act[c] && m_crv[c] == int'(crv)) ? m_y1[c] : 0;
      acc = b0 * x + b1 * x1 + fb * y1 + 16384;
      y = acc >>> 15;
      if (y > 64'sd8388607)  y = 64'sd8388607;
      if (y < -64'sd8388608) y = -64'sd8388608;
      m_x1[c] = x;
      m_y1[c] = y;
    end
    m_act[c] = act;
    m_crv[c] = int'(crv);
    return y;
  endfunction

  task automatic run_frame(input logic [1:0] crv, input logic [1:0] spd,
                           input logic [ND-1:0] en, input int gap);
    longint            exp [NCH];
    string             tg  [NCH];
    logic [NCH*DW-1:0] snap;
    @(negedge clk);
    curve_sel = crv;
    speed_sel = spd;
    dac_en    = en;
    for (int c = 0; c < NCH; c++) begin
      in_data[c*DW +: DW] = cur_x[c][DW-1:0];
      exp[c] = model(c, crv, spd, en, cur_x[c], tg[c]);
    end
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    check(out_valid === 1'b1, "R2", longint'(out_valid), 1);
    for (int c = 0; c < NCH; c++)
      check(out_data[c*DW +: DW] === exp[c][DW-1:0], tg[c],
            longint'(out_data[c*DW +: DW]), longint'(exp[c][DW-1:0]));
    snap = out_data;
    for (int g = 0; g < gap; g++) begin
      for (int c = 0; c < NCH; c++) in_data[c*DW +: DW] = rnd_sample()[DW-1:0];
      @(negedge clk);
      check(out_valid === 1'b0 && out_data === snap, "R2", longint'(out_valid), 0);
    end
  endtask

  task automatic set_all(input longint v);
    for (int c = 0; c < NCH; c++) cur_x[c] = v;
  endtask

  task automatic set_rand();
    for (int c = 0; c < NCH; c++) cur_x[c] = rnd_sample();
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [1:0]    crv, spd;
    logic [ND-1:0] en;
    void'($urandom(32'hDE_E1));
    for (int c = 0; c < NCH; c++) begin
      m_x1[c] = 0; m_y1[c] = 0; m_act[c] = 0; m_crv[c] = 0; cur_x[c] = 0;
    end
    rst_n = 1'b0; frame_stb = 1'b0; curve_sel = 2'b00; speed_sel = 2'b00;
    dac_en = '0; in_data = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1", longint'(out_valid), 0);
    check(out_data === '0, "R1", longint'(out_data[DW-1:0]), 0);
    rst_n = 1'b1;

    // R3: curve off passes samples through
    set_rand(); run_frame(2'b01, 2'b00, 3'b111, 1);
    set_rand(); run_frame(2'b01, 2'b00, 3'b111, 2);
    // R4: non-normal speed forces bypass
    set_rand(); run_frame(2'b00, 2'b01, 3'b111, 1);
    set_rand(); run_frame(2'b10, 2'b10, 3'b111, 1);
    set_rand(); run_frame(2'b11, 2'b11, 3'b111, 1);
    // R6/R7: step into the 44.1 kHz curve
    set_all(0);        run_frame(2'b00, 2'b00, 3'b111, 1);
    set_all(4000000);
    for (int i = 0; i < 6; i++) run_frame(2'b00, 2'b00, 3'b111, 1);
    // R7: curve change restarts history
    run_frame(2'b10, 2'b00, 3'b111, 1);
    run_frame(2'b10, 2'b00, 3'b111, 1);
    run_frame(2'b11, 2'b00, 3'b111, 2);
    run_frame(2'b11, 2'b00, 3'b111, 1);
    // R5: only converter 1 filters
    for (int i = 0; i < 4; i++) begin set_rand(); run_frame(2'b00, 2'b00, 3'b010, 1); end
    // R6: full-scale extremes
    set_all(-64'sd8388608);
    for (int i = 0; i < 4; i++) run_frame(2'b11, 2'b00, 3'b111, 1);
    for (int i = 0; i < 6; i++) begin
      set_all((i % 2 == 0) ? 64'sd8388607 : -64'sd8388608);
      run_frame(2'b00, 2'b00, 3'b111, 1);
    end

    // constrained random mix
    crv = 2'b00; spd = 2'b00; en = 3'b111;
    for (int i = 0; i < 800; i++) begin
      if ($urandom % 12 == 0) begin
        crv = 2'($urandom);
        spd = ($urandom % 5 == 0) ? 2'($urandom) : 2'b00;
        en  = ND'($urandom);
      end
      set_rand();
      run_frame(crv, spd, en, 1 + int'($urandom % 3));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule